// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock for an I2C master. It holds no registers of its own. Two pairs of 16-bit period counts arrive as inputs, one pair for standard speed and one for fast speed, and a speed-select input picks the pair in use. The block splits each SCL period into a driven-low phase and a released-high phase, and times both in system clock cycles.

SCL is open-drain, so the block never drives it high. One output asks the pad to pull the line low. The line itself comes back through a two-flop synchronizer. The high phase only starts counting once the synchronized line reads high, so a target that stretches the clock, or a slow rising edge, lengthens the high phase instead of cutting it short.

A bit engine built on top of this block uses two single-cycle strobes. One marks the first cycle in which SCL is pulled low. The other marks the cycle in which the high count begins, which is the data sample point. When the enable input drops, the line is released and every counter returns to its idle value.

Top module: `scl_period_gen`

## Requirements
- R1: One clock edge after `enable` is sampled low, `scl_pull_low` is 0 and both strobes are 0. They stay 0 for as long as `enable` stays low.
- R2: Each driven-low phase lasts exactly the selected low count plus 1 cycles, counted from the first cycle in which `scl_pull_low` is 1.
- R3: When no target holds SCL low, each released phase (`scl_pull_low` at 0) lasts exactly the selected high count plus 8 cycles.
- R4: When `fast_sel` is 1, the fast pair (`fs_high`, `fs_low`) is used. When it is 0, the standard pair (`ss_high`, `ss_low`) is used.
- R5: A selected high count below 6 is treated as 6.
- R6: A selected low count below 8 is treated as 8.
- R7: The high count starts only when the two-flop synchronized `scl_in` reads 1. If SCL is held low for S cycles beyond the release, the released phase lasts the high count plus 8 plus S cycles.
- R8: `fall_strobe` is 1 for exactly one cycle per period, and that cycle is the first cycle of each driven-low phase.
- R9: `sample_strobe` is 1 for exactly one cycle per period. With no stretching, that cycle is the fourth cycle of the released phase (index 3, counting from 0).
- R10: When `enable` rises from idle, `scl_pull_low` becomes 1 on the next clock edge, together with `fall_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the clock generator; low releases SCL and clears the counters |
| fast_sel | input | 1 | 1 selects the fast pair of counts, 0 selects the standard pair |
| ss_high | input | 16 | Standard-speed high count |
| ss_low | input | 16 | Standard-speed low count |
| fs_high | input | 16 | Fast-speed high count |
| fs_low | input | 16 | Fast-speed low count |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_pull_low | output | 1 | Open-drain enable: 1 pulls SCL low |
| fall_strobe | output | 1 | Single-cycle pulse on the first driven-low cycle |
| sample_strobe | output | 1 | Single-cycle pulse when the high count starts |

## Verification
Every output is registered. `scl_pull_low` and `fall_strobe` change one edge after `enable` changes. When SCL is released, the sensed line reaches the counter after two synchronizer edges, and `sample_strobe` rises on the third edge after the release. The released phase therefore always carries a fixed overhead on top of the high count. The bench models the line as released whenever neither the block nor a simulated target pulls it low. It samples on falling clock edges and measures phase lengths and strobe positions as the index of the cycle within each phase. Expected lengths come from the clamped counts plus 1 and plus 8, and a stretch shifts the sample index by exactly the cycles it was held.

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CW     = 16,
  parameter int MIN_HI = 6,
  parameter int MIN_LO = 8,
  parameter int HI_ADD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          fast_sel,
  input  logic [CW-1:0] ss_high,
  input  logic [CW-1:0] ss_low,
  input  logic [CW-1:0] fs_high,
  input  logic [CW-1:0] fs_low,
  input  logic          scl_in,
  output logic          scl_pull_low,
  output logic          fall_strobe,
  output logic          sample_strobe
);
  localparam int KW = CW + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAITH, S_HIGH} st_t;
  st_t           st;
  logic [KW-1:0] cnt;
  logic          sync1, sync2;
  logic [CW-1:0] hi_sel, lo_sel;
  logic [KW-1:0] hi_load, lo_load;

  assign hi_sel  = fast_sel ? fs_high : ss_high;
  assign lo_sel  = fast_sel ? fs_low  : ss_low;
  assign hi_load = (hi_sel < CW'(MIN_HI)) ? KW'(MIN_HI + HI_ADD) : ({1'b0, hi_sel} + KW'(HI_ADD));
  assign lo_load = (lo_sel < CW'(MIN_LO)) ? KW'(MIN_LO) : {1'b0, lo_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sync1 <= 1'b0; sync2 <= 1'b0;
      scl_pull_low <= 1'b0; fall_strobe <= 1'b0; sample_strobe <= 1'b0;
    end else begin
      sync1 <= scl_in;
      sync2 <= sync1;
      fall_strobe   <= 1'b0;
      sample_strobe <= 1'b0;
      if (!enable) begin
        st <= S_IDLE; cnt <= '0; scl_pull_low <= 1'b0;
      end else begin
        unique case (st)
          S_IDLE: begin
            st <= S_LOW; cnt <= lo_load; scl_pull_low <= 1'b1; fall_strobe <= 1'b1;
          end
          S_LOW: begin
            if (cnt == '0) begin
              st <= S_WAITH; scl_pull_low <= 1'b0;
            end else cnt <= cnt - 1'b1;
          end
          S_WAITH: begin
            if (sync2) begin
              st <= S_HIGH; cnt <= hi_load; sample_strobe <= 1'b1;
            end
          end
          S_HIGH: begin
            if (cnt == '0) begin
              st <= S_LOW; cnt <= lo_load; scl_pull_low <= 1'b1; fall_strobe <= 1'b1;
            end else cnt <= cnt - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull_low && !fall_strobe && !sample_strobe));

  // R8
  fall_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_strobe |-> (scl_pull_low && !sample_strobe));

  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_strobe |=> !fall_strobe);

  // R9
  sample_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> !scl_pull_low);

  // R7
  sample_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_strobe) |-> $past(sync2));

  // R10
  pull_starts_with_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> fall_strobe);
endmodule

// File: tb/scl_period_gen_bench.sv
module scl_period_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, fast_sel = 1'b0, stretch = 1'b0;
  logic [15:0] ss_high = 16'd20, ss_low = 16'd30, fs_high = 16'd9, fs_low = 16'd12;
  logic scl_in, scl_pull_low, fall_strobe, sample_strobe;
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;
  assign scl_in = ~(scl_pull_low | stretch);

  scl_period_gen u_scl_period_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
    .ss_high(ss_high), .ss_low(ss_low), .fs_high(fs_high), .fs_low(fs_low),
    .scl_in(scl_in), .scl_pull_low(scl_pull_low),
    .fall_strobe(fall_strobe), .sample_strobe(sample_strobe));

  // fast, ss_high, ss_low, fs_high, fs_low, expected low length, expected high length
  localparam int NV = 6;
  localparam int VEC [NV][7] = '{
    '{0, 20, 30,  9, 12, 31, 28},
    '{1, 20, 30,  9, 12, 13, 17},
    '{0,  2,  3,  9, 12,  9, 14},
    '{0,  6,  8,  9, 12,  9, 14},
    '{0,  7,  9,  9, 12, 10, 15},
    '{1, 20, 30,  0,  0,  9, 14}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic measure(input int s, output int lo_len, output int hi_len,
                         output int fall_ok, output int samp_idx);
    int nsamp;
    while (!scl_pull_low) @(negedge clk);
    lo_len = 0; fall_ok = 1;
    while (scl_pull_low) begin
      if ((lo_len == 0) != fall_strobe) fall_ok = 0;
      if (sample_strobe) fall_ok = 0;
      lo_len++;
      @(negedge clk);
    end
    hi_len = 0; samp_idx = -1; nsamp = 0;
    while (!scl_pull_low) begin
      if (hi_len == s) stretch = 1'b0;
      if (sample_strobe) begin samp_idx = hi_len; nsamp++; end
      if (fall_strobe) fall_ok = 0;
      hi_len++;
      @(negedge clk);
    end
    if (nsamp != 1) samp_idx = -2;
  endtask

  initial begin
    int lo_len, hi_len, fall_ok, samp_idx;
    #7 rst_n = 1'b1;
    @(negedge clk);
    check(!scl_pull_low && !fall_strobe && !sample_strobe, "R1 reset", scl_pull_low, 0);

    for (int i = 0; i < NV; i++) begin
      enable = 1'b0;
      fast_sel = VEC[i][0] != 0;
      ss_high = 16'(VEC[i][1]); ss_low = 16'(VEC[i][2]);
      fs_high = 16'(VEC[i][3]); fs_low = 16'(VEC[i][4]);
      repeat (3) @(negedge clk);
      enable = 1'b1;
      measure(0, lo_len, hi_len, fall_ok, samp_idx);
      measure(0, lo_len, hi_len, fall_ok, samp_idx);
      check(lo_len == VEC[i][5], "R2 R4 R6 low length", lo_len, VEC[i][5]);
      check(hi_len == VEC[i][6], "R3 R4 R5 high length", hi_len, VEC[i][6]);
      check(fall_ok == 1, "R8 fall strobe position", fall_ok, 1);
      check(samp_idx == 3, "R9 sample strobe index", samp_idx, 3);
    end

    // R10 start latency
    enable = 1'b0;
    fast_sel = 1'b0; ss_high = 16'd20; ss_low = 16'd30;
    repeat (3) @(negedge clk);
    check(!scl_pull_low, "R1 idle while disabled", scl_pull_low, 0);
    enable = 1'b1;
    @(negedge clk);
    check(scl_pull_low && fall_strobe, "R10 first pull", scl_pull_low, 1);

    // R7 stretching by 5 cycles
    stretch = 1'b1;
    measure(5, lo_len, hi_len, fall_ok, samp_idx);
    check(hi_len == 33, "R7 stretched high length", hi_len, 33);
    check(samp_idx == 8, "R7 sample after stretch", samp_idx, 8);
    stretch = 1'b0;

    // R1 disable in the middle of a low phase
    while (!scl_pull_low) @(negedge clk);
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!scl_pull_low && !fall_strobe, "R1 disable mid low", scl_pull_low, 0);
    begin
      int seen = 0;
      for (int k = 0; k < 40; k++) begin
        if (scl_pull_low || fall_strobe || sample_strobe) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R1 stays released", seen, 0);
    end

    // R1 disable in the middle of a high phase
    enable = 1'b1;
    while (!scl_pull_low) @(negedge clk);
    while (scl_pull_low) @(negedge clk);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!scl_pull_low && !sample_strobe, "R1 disable mid high", scl_pull_low, 0);

    finish_run();
  end
endmodule